// File: doc/BRIEF.md
# Dual Programmable Blink Rate Generator

This block turns a free-running system clock into two independent blink/dim waveforms. A shared divider first reduces the system clock to a base tick of 40 960 Hz, which is 256 phase steps times 160 Hz. Each of the two channels then divides that tick by its own 8-bit prescale value plus one and steps an 8-bit phase counter. The channel output is active while the phase is below the channel's 8-bit duty value. The period is therefore (prescale+1)/160 s and the duty cycle is duty/256.

The four 8-bit setting registers live outside the block and drive its inputs. The block takes a private copy of each channel's settings at two moments: in every cycle that reset is held, and at the step where that channel's phase wraps from 255 to 0. A setting change therefore never cuts a period short. An integrator who wants the customary power-up state (prescale 0x00, duty 0x80, 50 %) holds those values on the inputs while reset is applied.

Top module: `blink_rate_gen`

## Requirements
- R1: The shared divider produces one base tick every CLK_HZ/TICK_HZ system clocks. Ticks are never adjacent when that ratio exceeds one, and the first tick falls on the ratio-th rising edge after reset is released.
- R2: Each channel's phase counter advances by one on every (prescale+1)-th base tick and wraps from 255 to 0. It holds its value on every other clock.
- R3: A channel output is high exactly while its phase is less than its duty value. A duty of 0 never drives it high. A duty of 255 drives it low only during phase 255.
- R4: The two channels run independently: each uses only its own prescale and duty inputs.
- R5: A change on a channel's prescale or duty input has no effect on that channel's output until the phase wraps from 255 to 0. From that wrap on, the new values set both rate and duty.
- R6: A low level on rst_n at a clock edge clears the divider, both prescale counters and both phases, and loads both channels' settings from the inputs. During reset each output is therefore high exactly when its duty input is non-zero.
- R7: A channel period spans (prescale+1)*256 base ticks, which is (prescale+1)/160 s at the default tick rate. Its high time spans duty*(prescale+1) base ticks. Examples: prescale 31 gives 0.2 s, and prescale 159 with duty 64 gives a 1 s period that is 25 % high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psc0_i | input | 8 | Channel 0 prescale setting |
| duty0_i | input | 8 | Channel 0 duty setting |
| psc1_i | input | 8 | Channel 1 prescale setting |
| duty1_i | input | 8 | Channel 1 duty setting |
| dim0_o | output | 1 | Channel 0 blink waveform, high = active |
| dim1_o | output | 1 | Channel 1 blink waveform, high = active |

## Verification
Each output is decoded directly from registers. It therefore settles in the same clock as the edge that steps the phase, which is the k-th rising edge after reset release where k is the tick count times the divider ratio. The bench counts rising edges from reset release and samples both outputs at every falling edge. At each sample it compares them with an arithmetic expectation of the form floor(floor(k/ratio)/(prescale+1)) mod 256 < duty. A setting change is applied at a falling edge, so the first edge that sees it is the next rising edge. The expectation switches to the new settings at the first wrap edge after that change, so that old settings remain in force up to the wrap.

// File: rtl/blink_pkg.sv
// Package: shared widths and types for the dual blink rate generator.
// Assumes 8-bit phase and setting fields throughout.
package blink_pkg;
    localparam int PHASE_W  = 8;
    localparam int SET_W    = 8;
    localparam int NUM_CH   = 2;
    localparam logic [PHASE_W-1:0] PHASE_LAST = '1;

    typedef logic [SET_W-1:0]   set_t;
    typedef logic [PHASE_W-1:0] phase_t;

    // One channel's private copy of its settings
    typedef struct packed {
        set_t psc;
        set_t duty;
    } chan_cfg_t;
endpackage

// File: rtl/blink_tick_div.sv
// Module: blink_tick_div
// Divides the system clock down to a single-cycle base tick every DIV clocks.
// Assumes DIV >= 1; DIV == 1 yields a tick on every clock.
module blink_tick_div #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_count
            logic [CNT_W-1:0] cnt;

            // Count clocks, wrapping after DIV-1
            always_ff @(posedge clk) begin
                if (!rst_n)                       cnt <= '0;
                else if (cnt == CNT_W'(DIV - 1))  cnt <= '0;
                else                              cnt <= cnt + 1'b1;
            end

            assign tick = (cnt == CNT_W'(DIV - 1));

            // R1
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
            // R1
            cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt <= CNT_W'(DIV - 1));
        end else begin : g_every
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/blink_channel.sv
// Module: blink_channel
// One blink channel: a prescale counter on the base tick, an 8-bit phase
// counter, and a duty comparison. Settings are copied during reset and at the
// 255->0 phase wrap only, so a period is never cut short.
// Assumes tick is a single-cycle pulse from the shared divider.
module blink_channel
    import blink_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  set_t psc_i,
    input  set_t duty_i,
    output logic dim_o
);
    chan_cfg_t cfg_q;
    set_t      pre_cnt;
    phase_t    phase;
    logic      step;
    logic      wrap;

    assign step = tick && (pre_cnt == cfg_q.psc);
    assign wrap = step && (phase == PHASE_LAST);

    // Prescale counter: counts base ticks up to the held prescale value
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_cnt <= '0;
        else if (step) pre_cnt <= '0;
        else if (tick) pre_cnt <= pre_cnt + 1'b1;
    end

    // Phase counter: one step per prescale period, wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (step) phase <= phase + 1'b1;
    end

    // Settings copy: taken during reset and at the phase wrap
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) cfg_q <= '{psc: psc_i, duty: duty_i};
    end

    // Output decode from registers only
    assign dim_o = (phase < cfg_q.duty);

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));
    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(cfg_q));
    // R3
    zero_duty_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.duty == '0) |-> !dim_o);
    // R3
    dim_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dim_o));
endmodule

// File: rtl/blink_rate_gen.sv
// Module: blink_rate_gen
// Two independent blink/dim channels sharing one base-tick divider.
// Period = (psc+1)*256 base ticks, duty = duty/256.
// Assumes CLK_HZ is an integer multiple of TICK_HZ.
module blink_rate_gen
    import blink_pkg::*;
#(
    parameter int CLK_HZ  = 40_960_000,
    parameter int TICK_HZ = 40_960
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] psc0_i,
    input  logic [7:0] duty0_i,
    input  logic [7:0] psc1_i,
    input  logic [7:0] duty1_i,
    output logic       dim0_o,
    output logic       dim1_o
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic tick;
    set_t psc_a  [NUM_CH];
    set_t duty_a [NUM_CH];
    logic dim_a  [NUM_CH];

    assign psc_a[0]  = psc0_i;
    assign psc_a[1]  = psc1_i;
    assign duty_a[0] = duty0_i;
    assign duty_a[1] = duty1_i;
    assign dim0_o    = dim_a[0];
    assign dim1_o    = dim_a[1];

    blink_tick_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            blink_channel u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .psc_i  (psc_a[c]),
                .duty_i (duty_a[c]),
                .dim_o  (dim_a[c])
            );
        end
    endgenerate
endmodule

// File: tb/blink_rate_gen_tb.sv
// Bench: blink_rate_gen_tb
// Sweeps both channels over several settings with a divider ratio of 2 and
// compares each output at every falling edge against an arithmetic expectation.
module blink_rate_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] psc0 = 8'h00, duty0 = 8'h80, psc1 = 8'h00, duty1 = 8'h80;
    logic       dim0, dim1;

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    int kc     = 0;
    int po [2];
    int dold [2];
    int pn [2];
    int dn [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    blink_rate_gen #(.CLK_HZ(DIV * 40960), .TICK_HZ(40960)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .psc0_i (psc0), .duty0_i (duty0), .psc1_i (psc1), .duty1_i (duty1),
        .dim0_o (dim0), .dim1_o (dim1)
    );

    function automatic logic exp_dim(int kk, int kch, int p_o, int d_o, int p_n, int d_n);
        int t, lo, tw, ph;
        t  = kk / DIV;
        lo = 256 * (p_o + 1);
        tw = (kch / (lo * DIV) + 1) * lo;
        if (t < tw) begin
            ph = (t / (p_o + 1)) % 256;
            return ph < d_o;
        end
        ph = ((t - tw) / (p_n + 1)) % 256;
        return ph < d_n;
    endfunction

    task automatic check(string req, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s k=%0d actual=%0b expected=%0b", req, k, act, expv);
        end
    endtask

    task automatic check_int(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Settings: old set applied through reset, new set applied after edge kc
    task automatic setup(int p0, int d0, int p1, int d1,
                         int q0, int e0, int q1, int e1, int kchange);
        po[0] = p0; dold[0] = d0; po[1] = p1; dold[1] = d1;
        pn[0] = q0; dn[0] = e0; pn[1] = q1; dn[1] = e1;
        kc = kchange;
    endtask

    // Hold reset three edges with old settings, check reset outputs, release
    task automatic do_reset(string req);
        @(negedge clk);
        rst_n = 1'b0;
        psc0 = 8'(po[0]); duty0 = 8'(dold[0]); psc1 = 8'(po[1]); duty1 = 8'(dold[1]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req, dim0, dold[0] != 0);
        check(req, dim1, dold[1] != 0);
        rst_n = 1'b1;
        k = 0;
    endtask

    task automatic run(string req, int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (k == kc) begin
                psc0 = 8'(pn[0]); duty0 = 8'(dn[0]); psc1 = 8'(pn[1]); duty1 = 8'(dn[1]);
            end
            check(req, dim0, exp_dim(k, kc, po[0], dold[0], pn[0], dn[0]));
            check(req, dim1, exp_dim(k, kc, po[1], dold[1], pn[1], dn[1]));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int rise0 [2];
        int nr, fall1;
        logic prev0, prev1;

        // R6: reset state with the customary 0x00 / 0x80 settings
        setup(0, 128, 0, 128, 0, 128, 0, 128, 0);
        do_reset("R6 reset default");

        // R1 R2 R3 R4: distinct rate and duty per channel
        setup(0, 64, 3, 192, 0, 64, 3, 192, 0);
        do_reset("R6 reset");
        run("R1 R2 R4 steady", 4096);

        // R6: reset after running clears state; R3 duty extremes 0 and 255
        setup(0, 0, 0, 255, 0, 0, 0, 255, 0);
        do_reset("R6 reset midrun");
        run("R3 duty extremes", 1024);

        // R5: settings changed mid-period wait for the wrap
        setup(1, 32, 0, 128, 0, 224, 2, 16, 300);
        do_reset("R6 reset");
        run("R5 change at wrap", 6000);

        // R7: period and high time measured in clocks
        setup(31, 128, 159, 64, 31, 128, 159, 64, 0);
        do_reset("R6 reset");
        nr = 0; fall1 = -1; prev0 = dim0; prev1 = dim1;
        rise0[0] = 0; rise0[1] = 0;
        for (int i = 0; i < 33000; i++) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (dim0 && !prev0 && nr < 2) begin
                rise0[nr] = k;
                nr++;
            end
            if (!dim1 && prev1 && fall1 < 0) fall1 = k;
            prev0 = dim0;
            prev1 = dim1;
        end
        check_int("R7 first rise psc 31", rise0[0], 256 * 32 * DIV);
        check_int("R7 period psc 31", rise0[1] - rise0[0], 256 * 32 * DIV);
        check_int("R7 high time psc 159 duty 64", fall1, 64 * 160 * DIV);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule